// File: doc/BRIEF.md
# Serial Program/Verify Target Controller

This block is the target-side end of a two-wire serial programming link for a flash array of 14-bit words with a 16K-word address space. While the program-mode enable is high, it samples a serial clock and a data line. It collects 6-bit commands on falling clock edges and moves 16-bit payload frames in both directions. Outbound frames use a separate output and output-enable pair, which the pad logic joins into one bidirectional line.

A forward-only program counter addresses the memory-side port. Loads fill a pending word, and a begin command raises a program strobe that holds until an end command. An internal sweeper clears words one per clock for row and bulk erases. Code protection, the configuration half of the space and the fixed identity and calibration words limit what may be changed. The flash array is outside the block. The memory-side port gives the array a word address, a word to write, a program level and a clear strobe, and takes back the read word.

Top module: `spv_target`

## Requirements
- R1: After reset, and while `pgm_en` is low, `mem_addr` is 0x0000, `sdat_oe` is 0, and `mem_prog` and `mem_clr` are low.
- R2: A command is 6 bits taken on falling edges of `sck`, least significant bit first. The codes are: load config 0x00, load data 0x02, read 0x04, increment 0x06, begin 0x08, end 0x0A, bulk erase 0x09, row erase 0x11. Any other code has no effect, and the next command is decoded normally.
- R3: Load data is followed by a 16-bit frame: a start bit, then 14 data bits least significant first, then a stop bit. After the frame, `mem_wdata` shows the 14-bit word.
- R4: Load config takes the same frame, latches the word onto `mem_wdata` and sets the address to 0x2000.
- R5: Increment adds one to the address. The address never steps backwards and returns to 0 only on leaving program mode.
- R6: After a read command, `sdat_oe` is high for the next 16 bit periods. Bit period k drives the start bit 0, then the addressed word least significant first, then the stop bit 0. `sdat_oe` falls after the 16th falling edge.
- R7: Begin raises `mem_prog` with `mem_addr` at the counter and `mem_wdata` at the pending word. `mem_prog` stays high until an end command.
- R8: Begin is refused when the address is 0x2006, so the device-identity word is never written.
- R9: Row erase gives 16 `mem_clr` pulses, one per clock, over addresses {pc[11:4],0000}. It is refused when `code_prot` is high or when address bit 13 is set.
- R10: Bulk erase clears every user word below USER_WORDS and then word 0x2007. It never clears 0x2000–0x2003, 0x2006 or 0x2008.
- R11: Dropping `pgm_en` returns the address to 0, discards a partly shifted command, ends `mem_prog` and stops an erase sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgm_en | input | 1 | Program mode enable (high-voltage detect result) |
| code_prot | input | 1 | Code protection active |
| sck | input | 1 | Serial clock from the programmer |
| sdat_in | input | 1 | Serial data from the pad |
| sdat_out | output | 1 | Serial data to the pad during reads |
| sdat_oe | output | 1 | Pad output enable |
| mem_addr | output | 14 | Word address to the array |
| mem_wdata | output | 14 | Pending word to program |
| mem_rdata | input | 14 | Word read at mem_addr |
| mem_prog | output | 1 | Program level, write at rising edge |
| mem_clr | output | 1 | Clear-word strobe (word becomes all ones) |

## Verification
The row-erase window is the hardest state to reach from the pins. The counter only steps forward, so the stimulus has to issue a long run of increments to land inside a chosen 16-word row. It then must erase once with protection high and once with it low, and check the words just outside the row. Leaving program mode partway through a command is reached by clocking three bits and dropping the enable. A complete increment afterwards has to land on address 1, which shows the stale bits were discarded.

// File: rtl/spv_pkg.sv
package spv_pkg;
   localparam int CMD_W = 6;
   localparam logic [CMD_W-1:0] OP_LDCFG = 6'h00;
   localparam logic [CMD_W-1:0] OP_LDDAT = 6'h02;
   localparam logic [CMD_W-1:0] OP_READ  = 6'h04;
   localparam logic [CMD_W-1:0] OP_INC   = 6'h06;
   localparam logic [CMD_W-1:0] OP_BEGIN = 6'h08;
   localparam logic [CMD_W-1:0] OP_END   = 6'h0A;
   localparam logic [CMD_W-1:0] OP_BULK  = 6'h09;
   localparam logic [CMD_W-1:0] OP_ROW   = 6'h11;

   typedef enum logic [1:0] {ST_CMD, ST_LOAD, ST_READ} spv_state_e;
endpackage

// File: rtl/spv_edge.sv
module spv_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic dat_i,
   output logic fall_o,
   output logic dat_o
);
   logic sck_s, dat_s, sck_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign sck_s = sck_i;
         assign dat_s = dat_i;
      end else begin : g_sync
         logic [STAGES-1:0] sck_p, dat_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_p <= '0;
               dat_p <= '0;
            end else begin
               sck_p[0] <= sck_i;
               dat_p[0] <= dat_i;
               for (int i = 1; i < STAGES; i++) begin
                  sck_p[i] <= sck_p[i-1];
                  dat_p[i] <= dat_p[i-1];
               end
            end
         end
         assign sck_s = sck_p[STAGES-1];
         assign dat_s = dat_p[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   assign fall_o = sck_q & ~sck_s;
   assign dat_o  = dat_s;
endmodule

// File: rtl/spv_eraser.sv
module spv_eraser #(
   parameter int ADDR_W     = 14,
   parameter int USER_WORDS = 1024,
   parameter int ROW_WORDS  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              go_bulk,
   input  logic              go_row,
   input  logic [ADDR_W-1:0] row_base,
   output logic              busy,
   output logic              clr,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(1) << (ADDR_W-1);
   localparam logic [ADDR_W-1:0] CFG_WORD = CFG_BASE + ADDR_W'(7);
   localparam logic [ADDR_W-1:0] USER_TOP = ADDR_W'(USER_WORDS - 1);
   localparam logic [ADDR_W-1:0] ROW_SPAN = ADDR_W'(ROW_WORDS - 1);

   logic [ADDR_W-1:0] last;
   logic              tail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; addr <= '0; last <= '0; tail <= 1'b0;
      end else if (abort) begin
         busy <= 1'b0; tail <= 1'b0;
      end else if (busy) begin
         if (addr == last) begin
            if (tail) begin
               addr <= CFG_WORD; last <= CFG_WORD; tail <= 1'b0;
            end else begin
               busy <= 1'b0;
            end
         end else begin
            addr <= addr + ADDR_W'(1);
         end
      end else if (go_bulk) begin
         busy <= 1'b1; addr <= '0; last <= USER_TOP; tail <= 1'b1;
      end else if (go_row) begin
         busy <= 1'b1; addr <= row_base; last <= row_base + ROW_SPAN; tail <= 1'b0;
      end
   end

   assign clr = busy;

   // R10: identity, user-ID and calibration words are never cleared
   a_r10_spare_words: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !((addr >= CFG_BASE && addr <= CFG_BASE + ADDR_W'(6)) || addr == CFG_BASE + ADDR_W'(8)));
   // R9: inside configuration space only the configuration word is cleared
   a_r9_cfg_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && addr[ADDR_W-1]) |-> addr == CFG_WORD);
   // R11: abort stops the sweep
   a_r11_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy);
endmodule

// File: rtl/spv_target.sv
module spv_target #(
   parameter int ADDR_W      = 14,
   parameter int DATA_W      = 14,
   parameter int USER_WORDS  = 1024,
   parameter int ROW_WORDS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pgm_en,
   input  logic              code_prot,
   input  logic              sck,
   input  logic              sdat_in,
   output logic              sdat_out,
   output logic              sdat_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_prog,
   output logic              mem_clr
);
   import spv_pkg::*;

   localparam int FRAME_BITS = DATA_W + 2;
   localparam int CNT_W      = $clog2(FRAME_BITS);
   localparam int ROW_LSB    = $clog2(ROW_WORDS);
   localparam logic [CNT_W-1:0]  CMD_LAST   = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0]  FRAME_LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0]  DATA_LAST  = CNT_W'(DATA_W);
   localparam logic [ADDR_W-1:0] CFG_BASE   = ADDR_W'(1) << (ADDR_W-1);
   localparam logic [ADDR_W-1:0] DEVID      = CFG_BASE + ADDR_W'(6);

   initial begin
      assert (ADDR_W > 12) else $fatal(1, "ADDR_W must exceed 12");
      assert (USER_WORDS > 0 && USER_WORDS <= (1 << (ADDR_W-1))) else $fatal(1, "USER_WORDS range");
      assert (ROW_WORDS > 1 && (ROW_WORDS & (ROW_WORDS-1)) == 0) else $fatal(1, "ROW_WORDS power of two");
      assert (CMD_W <= FRAME_BITS) else $fatal(1, "frame shorter than command");
   end

   spv_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [CMD_W-1:0]  cmd_sh, cmd_nx;
   logic [DATA_W-1:0] shreg, pending;
   logic [ADDR_W-1:0] pc, row_base, ers_addr;
   logic              ld_cfg, prog, fall, dat, cmd_done;
   logic              go_bulk, go_row, ers_busy, ers_clr;

   spv_edge #(.STAGES(SYNC_STAGES)) i_edge (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .dat_i(sdat_in), .fall_o(fall), .dat_o(dat));

   assign cmd_nx   = {dat, cmd_sh[CMD_W-1:1]};
   assign cmd_done = pgm_en && fall && st == ST_CMD && cnt == CMD_LAST;
   assign go_bulk  = cmd_done && cmd_nx == OP_BULK;
   assign go_row   = cmd_done && cmd_nx == OP_ROW && !code_prot && !pc[ADDR_W-1];
   assign row_base = {{(ADDR_W-12){1'b0}}, pc[11:ROW_LSB], {ROW_LSB{1'b0}}};

   spv_eraser #(.ADDR_W(ADDR_W), .USER_WORDS(USER_WORDS), .ROW_WORDS(ROW_WORDS)) i_eraser (
      .clk(clk), .rst_n(rst_n), .abort(!pgm_en), .go_bulk(go_bulk), .go_row(go_row),
      .row_base(row_base), .busy(ers_busy), .clr(ers_clr), .addr(ers_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_CMD; cnt <= '0; cmd_sh <= '0; shreg <= '0; pending <= '0;
         pc <= '0; ld_cfg <= 1'b0; prog <= 1'b0;
      end else if (!pgm_en) begin
         st <= ST_CMD; cnt <= '0; cmd_sh <= '0; pc <= '0; prog <= 1'b0;
      end else if (fall) begin
         unique case (st)
            ST_CMD: begin
               if (cnt == CMD_LAST) begin
                  cnt <= '0;
                  cmd_sh <= '0;
                  case (cmd_nx)
                     OP_LDCFG: begin st <= ST_LOAD; ld_cfg <= 1'b1; end
                     OP_LDDAT: begin st <= ST_LOAD; ld_cfg <= 1'b0; end
                     OP_READ:  begin st <= ST_READ; shreg <= mem_rdata; end
                     OP_INC:   pc <= pc + ADDR_W'(1);
                     OP_BEGIN: if (pc != DEVID) prog <= 1'b1;
                     OP_END:   prog <= 1'b0;
                     default:  ;
                  endcase
               end else begin
                  cnt <= cnt + CNT_W'(1);
                  cmd_sh <= cmd_nx;
               end
            end
            ST_LOAD: begin
               if (cnt != '0 && cnt <= DATA_LAST) shreg <= {dat, shreg[DATA_W-1:1]};
               if (cnt == FRAME_LAST) begin
                  pending <= shreg;
                  if (ld_cfg) pc <= CFG_BASE;
                  st <= ST_CMD;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            ST_READ: begin
               if (cnt != '0) shreg <= shreg >> 1;
               if (cnt == FRAME_LAST) begin
                  st <= ST_CMD;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: st <= ST_CMD;
         endcase
      end
   end

   assign sdat_oe   = (st == ST_READ);
   assign sdat_out  = sdat_oe && cnt != '0 && cnt != FRAME_LAST && shreg[0];
   assign mem_addr  = ers_busy ? ers_addr : pc;
   assign mem_wdata = pending;
   assign mem_prog  = prog;
   assign mem_clr   = ers_clr;

   // R5: counter holds, steps by one, or jumps to the configuration base
   a_r5_pc_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_en && $past(pgm_en)) |-> (pc == $past(pc) || pc == $past(pc) + ADDR_W'(1) || pc == CFG_BASE));
   // R8: program level never starts on the identity word
   a_r8_devid_guard: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_prog) |-> $past(pc) != DEVID);
   // R6: output drive begins only right after a decoded command
   a_r6_oe_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdat_oe) |-> $past(cmd_done));
   // R11: leaving program mode clears counter, program level and drive
   a_r11_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !pgm_en |=> (pc == '0 && !mem_prog && !sdat_oe));
endmodule

// File: tb/test_spv_target.sv
module test_spv_target;
   localparam int USERW = 1024;

   logic clk = 1'b0, rst_n = 1'b0, pgm_en = 1'b0, code_prot = 1'b0, sck = 1'b0, sdat_in = 1'b0;
   logic sdat_out, sdat_oe, mem_prog, mem_clr;
   logic [13:0] mem_addr, mem_wdata, mem_rdata;

   int checks = 0, failures = 0, clr_cnt = 0;
   bit done = 0;

   logic [13:0] user_m [USERW];
   logic [13:0] cfg_m  [16];
   logic        prog_q = 1'b0;

   localparam logic [13:0] VEC [6] = '{14'h0000, 14'h3FFF, 14'h1555, 14'h2AAA, 14'h0001, 14'h2000};

   always #5 clk = ~clk;

   spv_target i_spv_target (
      .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .code_prot(code_prot), .sck(sck),
      .sdat_in(sdat_in), .sdat_out(sdat_out), .sdat_oe(sdat_oe), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_prog(mem_prog), .mem_clr(mem_clr));

   always_comb begin
      if (mem_addr < 14'(USERW))                 mem_rdata = user_m[mem_addr[9:0]];
      else if (mem_addr[13:4] == 10'h200)        mem_rdata = cfg_m[mem_addr[3:0]];
      else                                       mem_rdata = 14'h3FFF;
   end

   task automatic mem_put(input logic [13:0] a, input logic [13:0] d);
      if (a < 14'(USERW)) user_m[a[9:0]] = d;
      else if (a[13:4] == 10'h200) cfg_m[a[3:0]] = d;
   endtask

   always @(posedge clk) begin
      if (mem_clr) begin clr_cnt++; mem_put(mem_addr, 14'h3FFF); end
      if (mem_prog && !prog_q) mem_put(mem_addr, mem_wdata);
      prog_q <= mem_prog;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); sdat_in = b; sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
      wait_clk(4);
   endtask

   task automatic send_cmd(input logic [5:0] c);
      for (int i = 0; i < 6; i++) send_bit(c[i]);
      wait_clk(4);
   endtask

   task automatic send_frame(input logic [13:0] w);
      send_bit(1'b0);
      for (int i = 0; i < 14; i++) send_bit(w[i]);
      send_bit(1'b0);
      wait_clk(4);
   endtask

   task automatic read_frame(output logic [15:0] f, output bit oe_all);
      oe_all = 1;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk); sck = 1'b1;
         wait_clk(4);
         f[k] = sdat_out;
         oe_all &= sdat_oe;
         sck = 1'b0;
         wait_clk(4);
      end
      wait_clk(4);
   endtask

   task automatic read_word(input string req, input logic [13:0] exp);
      logic [15:0] f;
      bit oe_all;
      send_cmd(6'h04);
      read_frame(f, oe_all);
      chk(f[14:1] == exp, req, f[14:1], exp);
      chk(!f[0] && !f[15] && oe_all && !sdat_oe, "R6 frame", {f[15], f[0], oe_all, sdat_oe}, 4'b0010);
   endtask

   task automatic inc_n(input int n);
      for (int i = 0; i < n; i++) send_cmd(6'h06);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int c0;
      int bad;
      for (int j = 0; j < USERW; j++) user_m[j] = 14'(j) ^ 14'h1000;
      for (int j = 0; j < 16; j++) cfg_m[j] = 14'h3FFF;
      cfg_m[0] = 14'h0011; cfg_m[1] = 14'h0022; cfg_m[2] = 14'h0033; cfg_m[3] = 14'h0044;
      cfg_m[6] = 14'h0A5C; cfg_m[7] = 14'h0C0C; cfg_m[8] = 14'h1234;

      wait_clk(5); rst_n = 1'b1; wait_clk(5);
      // R1 reset state
      chk(mem_addr == 0 && !sdat_oe && !mem_prog && !mem_clr, "R1 reset", {mem_addr, sdat_oe, mem_prog, mem_clr}, 0);
      pgm_en = 1'b1; wait_clk(5);

      // R3/R5/R6/R7 table walk
      foreach (VEC[i]) begin
         send_cmd(6'h02); send_frame(VEC[i]);
         chk(mem_wdata == VEC[i], "R3 load data", mem_wdata, VEC[i]);
         send_cmd(6'h08);
         chk(mem_prog, "R7 begin", mem_prog, 1);
         send_cmd(6'h0A);
         chk(!mem_prog && user_m[i] == VEC[i], "R7 write", user_m[i], VEC[i]);
         read_word("R6 read", VEC[i]);
         send_cmd(6'h06);
         chk(mem_addr == 14'(i + 1), "R5 increment", mem_addr, i + 1);
      end

      // R2 unknown code ignored, decoding continues
      c0 = clr_cnt;
      send_cmd(6'h3F);
      chk(mem_addr == 6 && !mem_prog && !sdat_oe && clr_cnt == c0, "R2 unknown code", mem_addr, 6);
      read_word("R2 next command", 14'h1006);

      // R11 partial command discarded on exit
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      pgm_en = 1'b0; wait_clk(6);
      chk(mem_addr == 0, "R11 exit resets address", mem_addr, 0);
      pgm_en = 1'b1; wait_clk(4);
      send_cmd(6'h06);
      chk(mem_addr == 1, "R11 shift reset", mem_addr, 1);

      // R9 row erase
      inc_n(18);
      chk(mem_addr == 14'h13, "R5 walk", mem_addr, 14'h13);
      code_prot = 1'b1; c0 = clr_cnt;
      send_cmd(6'h11); wait_clk(30);
      chk(clr_cnt == c0 && user_m[14'h13] == 14'h1013, "R9 protected refused", clr_cnt - c0, 0);
      code_prot = 1'b0; c0 = clr_cnt;
      send_cmd(6'h11); wait_clk(30);
      chk(clr_cnt - c0 == 16, "R9 row pulses", clr_cnt - c0, 16);
      chk(user_m[14'h10] == 14'h3FFF && user_m[14'h1F] == 14'h3FFF, "R9 row cleared", user_m[14'h10], 14'h3FFF);
      chk(user_m[14'h0F] == 14'h100F && user_m[14'h20] == 14'h1020, "R9 neighbours kept", user_m[14'h20], 14'h1020);
      read_word("R9 readback", 14'h3FFF);

      // R4 load config
      send_cmd(6'h00); send_frame(14'h0ABC);
      chk(mem_addr == 14'h2000 && mem_wdata == 14'h0ABC, "R4 load config", mem_addr, 14'h2000);
      send_cmd(6'h08); send_cmd(6'h0A);
      chk(cfg_m[0] == 14'h0ABC, "R4 config write", cfg_m[0], 14'h0ABC);
      c0 = clr_cnt;
      send_cmd(6'h11); wait_clk(30);
      chk(clr_cnt == c0, "R9 config space refused", clr_cnt - c0, 0);

      // R8 identity word protected
      inc_n(6);
      chk(mem_addr == 14'h2006, "R5 to identity", mem_addr, 14'h2006);
      send_cmd(6'h02); send_frame(14'h0111);
      send_cmd(6'h08);
      chk(!mem_prog, "R8 begin refused", mem_prog, 0);
      send_cmd(6'h0A);
      chk(cfg_m[6] == 14'h0A5C, "R8 identity kept", cfg_m[6], 14'h0A5C);
      read_word("R8 identity read", 14'h0A5C);

      // R7 level held until end
      send_cmd(6'h06); send_cmd(6'h08); wait_clk(20);
      chk(mem_prog && mem_addr == 14'h2007, "R7 level held", mem_prog, 1);
      send_cmd(6'h0A);
      chk(!mem_prog, "R7 end stops", mem_prog, 1'b0);

      // R11 exit during program level
      send_cmd(6'h08);
      pgm_en = 1'b0; wait_clk(4);
      chk(!mem_prog && mem_addr == 0, "R11 exit ends program", mem_prog, 0);
      pgm_en = 1'b1; wait_clk(4);

      // R10 bulk erase
      c0 = clr_cnt;
      send_cmd(6'h09); wait_clk(1100);
      bad = 0;
      for (int j = 0; j < USERW; j++) if (user_m[j] != 14'h3FFF) bad++;
      chk(bad == 0, "R10 user cleared", bad, 0);
      chk(clr_cnt - c0 == USERW + 1, "R10 pulse count", clr_cnt - c0, USERW + 1);
      chk(cfg_m[7] == 14'h3FFF, "R10 config word cleared", cfg_m[7], 14'h3FFF);
      chk(cfg_m[0] == 14'h0ABC && cfg_m[1] == 14'h0022 && cfg_m[2] == 14'h0033 && cfg_m[3] == 14'h0044,
          "R10 user-ID kept", cfg_m[3], 14'h0044);
      chk(cfg_m[6] == 14'h0A5C && cfg_m[8] == 14'h1234, "R10 identity and calibration kept", cfg_m[8], 14'h1234);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule